// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block maps an 8-bit CPU's view of a cartridge onto its program and character memories. The CPU configures it purely by writing to decoded addresses. The block holds a bank byte, a mode byte and seven page bytes. From these it forms four program page numbers, one for each 8 KB CPU window at 0x8000, 0xA000, 0xC000 and 0xE000. It also forms four character page numbers, one for each 2 KB video window, and a nametable mirroring select.

Three program layouts are available:
- Split: a selectable 16 KB half, with the upper 16 KB fixed to the end of program memory.
- Whole: one selectable 32 KB block.
- Per-window: three independently paged 8 KB windows plus a fixed last window, all sharing an outer bit taken from the bank byte.

A low I/O area holds four general-purpose scratch bytes. A second small area reads back two configuration switch bits. Every page output is a combinational function of the stored bytes, so a write takes effect on the very next bus access. A power-up reset clears all state. A soft reset clears only the bank and mode bytes.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with cpu_addr[15]=1 is decoded on (cpu_addr AND 0x8C17). A result of 0x8000 loads the bank byte and 0x8400 loads the mode byte. Any result not listed in R1 or R2 changes no state; this includes 0x8800, 0x8801 and 0x8C03.
- R2: Decoded values 0x8C00, 0x8C01 and 0x8C02 load page bytes 0 to 2. Decoded values 0x8C10, 0x8C11, 0x8C16 and 0x8C17 load page bytes 3 to 6. Character output window k (chr_pages[8k+7:8k]) equals page byte 3+k.
- R3: mirror_horiz equals mode bit 0 (1 = horizontal, 0 = vertical).
- R4: When mode bit 4 is 1, program window w (prg_pages[5w+4:5w]) takes bank bit 3 as its bit 4. For w = 0..2 the low nibble is bits [3:0] of page byte w; window 3 uses a low nibble of 0xF. Mode bit 4 overrides mode bit 3.
- R5: When mode bit 4 is 0 and mode bit 3 is 1, window w = ((bank AND 0xFE) << 1) + w, truncated to 5 bits.
- R6: When mode bits 4 and 3 are both 0, window 0 = bank << 1 and window 1 = (bank << 1) + 1, both truncated to 5 bits. Window 2 = 30 and window 3 = 31.
- R7: A write to 0x5400..0x5FFF stores into the scratch byte selected by cpu_addr[1:0]. cpu_rdata returns that byte whenever cpu_addr is in the same range.
- R8: For cpu_addr in 0x5000..0x53FF, cpu_rdata = {bus_hi, cfg_sw}, and writes there change no scratch byte. Any other address below 0x8000 reads as 0x00.
- R9: soft_rst (synchronous, active high) clears the bank and mode bytes at the next clock edge. It leaves the page and scratch bytes unchanged and takes priority over a write to bank or mode in the same cycle.
- R10: rst_n low clears every stored byte. The outputs are then prg 0,1,30,31, chr all 0 and mirror_horiz 0.
- R11: Outputs reflect a register write in the cycle right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_hi | input | 6 | Last value seen on data bus bits 7..2 |
| cfg_sw | input | 2 | Configuration switch bits |
| cpu_rdata | output | 8 | Combinational read data for cpu_addr |
| prg_pages | output | 20 | Four 5-bit 8 KB program page numbers, window 0 in the low bits |
| chr_pages | output | 32 | Four 8-bit 2 KB character page numbers, window 0 in the low bits |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The assertions check several properties on every clock:
- At most one target is strobed per write.
- A write in the switch area never strobes storage.
- A soft reset clears bank and mode while leaving the page bytes untouched.
- Each program layout keeps its structural invariant: a fixed last window in per-window mode, contiguous windows in whole mode, and a fixed top half in split mode.

Only the bench's scenarios can show the exact page numbers, because those depend on the values written. The same holds for address aliasing through the sparse mask, for scratch read-back, for switch read-back beside open-bus bits, and for what survives each kind of reset.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int unsigned REG_BANK   = 0;
  localparam int unsigned REG_MODE   = 1;
  localparam int unsigned REG_PAGE0  = 2;
  localparam int unsigned NUM_PAGE   = 7;
  localparam int unsigned NUM_REGS   = REG_PAGE0 + NUM_PAGE;
  localparam int unsigned NUM_WIN    = 4;

  localparam int unsigned MODE_MIRROR = 0;
  localparam int unsigned MODE_WHOLE  = 3;
  localparam int unsigned MODE_PERWIN = 4;

  localparam logic [15:0] HI_MASK = 16'h8C17;

  typedef enum logic [1:0] {
    LAYOUT_SPLIT  = 2'd0,
    LAYOUT_WHOLE  = 2'd1,
    LAYOUT_PERWIN = 2'd2
  } layout_e;

  // Target register slot for a high-area write; NUM_REGS means no target.
  function automatic logic [3:0] hi_slot(input logic [15:0] addr);
    logic [3:0] s;
    case (addr & HI_MASK)
      16'h8000: s = 4'(REG_BANK);
      16'h8400: s = 4'(REG_MODE);
      16'h8C00: s = 4'(REG_PAGE0 + 0);
      16'h8C01: s = 4'(REG_PAGE0 + 1);
      16'h8C02: s = 4'(REG_PAGE0 + 2);
      16'h8C10: s = 4'(REG_PAGE0 + 3);
      16'h8C11: s = 4'(REG_PAGE0 + 4);
      16'h8C16: s = 4'(REG_PAGE0 + 5);
      16'h8C17: s = 4'(REG_PAGE0 + 6);
      default:  s = 4'(NUM_REGS);
    endcase
    return s;
  endfunction

  function automatic layout_e layout_of(input logic [7:0] mode);
    if (mode[MODE_PERWIN])     return LAYOUT_PERWIN;
    else if (mode[MODE_WHOLE]) return LAYOUT_WHOLE;
    else                       return LAYOUT_SPLIT;
  endfunction

  // Full-width 8 KB page number for window win; caller truncates.
  function automatic logic [15:0] win_page(input logic [7:0]  mode,
                                           input logic [7:0]  bank,
                                           input logic [7:0]  page,
                                           input logic [1:0]  win,
                                           input logic [15:0] last);
    logic [15:0] r;
    case (layout_of(mode))
      LAYOUT_PERWIN: begin
        if (win == 2'd3) r = {11'd0, bank[3], 4'hF};
        else             r = {11'd0, bank[3], page[3:0]};
      end
      LAYOUT_WHOLE:
        r = {7'd0, (bank & 8'hFE), 1'b0} + 16'(win);
      default: begin
        if (win[1]) r = last - 16'd1 + 16'(win[0]);
        else        r = {7'd0, bank, 1'b0} + 16'(win[0]);
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         addr,
  input  logic                we,
  output logic [NUM_REGS-1:0] reg_wr,
  output logic                scr_wr,
  output logic                sw_area,
  output logic                scr_area
);

  logic       hi_area;
  logic [3:0] slot;

  always_comb begin
    hi_area  = addr[15];
    sw_area  = (addr[15:10] == 6'b010100);
    scr_area = (addr[15:12] == 4'h5) && (addr[11:10] != 2'b00);
    slot     = hi_slot(addr);
  end

  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_strobe
      assign reg_wr[i] = we && hi_area && (slot == 4'(i));
    end
  endgenerate

  assign scr_wr = we && scr_area;

  // R1: a single write never reaches two targets
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, scr_wr}));

  // R8: writes into the switch area strobe nothing
  a_r8_switch_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sw_area) |-> (!scr_wr && (reg_wr == '0)));

endmodule

// File: rtl/cbc_regfile.sv
module cbc_regfile
  import cbc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           soft_rst,
  input  logic [NUM_REGS-1:0]            reg_wr,
  input  logic [7:0]                     wdata,
  output logic [7:0]                     bank_q,
  output logic [7:0]                     mode_q,
  output logic [NUM_PAGE-1:0][7:0]       page_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      mode_q <= '0;
    end else if (soft_rst) begin
      bank_q <= '0;
      mode_q <= '0;
    end else begin
      if (reg_wr[REG_BANK]) bank_q <= wdata;
      if (reg_wr[REG_MODE]) mode_q <= wdata;
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PAGE; p++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    page_q[p] <= '0;
        else if (reg_wr[REG_PAGE0+p])  page_q[p] <= wdata;
      end
    end
  endgenerate

  // R9: soft reset clears bank and mode on the next edge
  a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank_q == 8'h00 && mode_q == 8'h00));

  // R9: soft reset leaves page bytes alone
  a_r9_pages_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && reg_wr[NUM_REGS-1:REG_PAGE0] == '0) |=> $stable(page_q));

endmodule

// File: rtl/cbc_scratch.sv
module cbc_scratch #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [$clog2(DEPTH)-1:0] sel,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata
);

  logic [DEPTH-1:0][7:0] mem_q;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mem_q[i] <= '0;
        else if (wr && sel == i[$clog2(DEPTH)-1:0]) mem_q[i] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem_q[sel];

  // R7: a write is readable at the same slot on the next cycle
  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mem_q[$past(sel)] == $past(wdata)));

endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
  import cbc_pkg::*;
#(
  parameter int unsigned PRG_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               mode,
  input  logic [7:0]               bank,
  input  logic [2:0][7:0]          page_lo,
  output logic [NUM_WIN*PRG_W-1:0] prg_pages
);

  localparam logic [15:0] LAST_PAGE = 16'((1 << PRG_W) - 1);

  logic [NUM_WIN-1:0][PRG_W-1:0] win_q;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      logic [15:0] full;
      always_comb begin
        full = win_page(mode, bank, (w < 3) ? page_lo[(w < 3) ? w : 0] : 8'h00,
                        2'(w), LAST_PAGE);
      end
      assign win_q[w] = full[PRG_W-1:0];
      assign prg_pages[w*PRG_W +: PRG_W] = win_q[w];
    end
  endgenerate

  // R4: last window is pinned to nibble 0xF in per-window layout
  a_r4_last_window: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MODE_PERWIN] |-> (win_q[3][3:0] == 4'hF));

  // R5: whole-block layout gives four consecutive pages
  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[MODE_PERWIN] && mode[MODE_WHOLE]) |->
      (win_q[1] == PRG_W'(win_q[0] + 1'b1) && win_q[3] == PRG_W'(win_q[2] + 1'b1)));

  // R6: split layout pins the top half to the last two pages
  a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[MODE_PERWIN] && !mode[MODE_WHOLE]) |->
      (&win_q[3] && win_q[2] == {{(PRG_W-1){1'b1}}, 1'b0}));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned PRG_W   = 5,
  parameter int unsigned SCR_N   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic [15:0]              cpu_addr,
  input  logic [7:0]               cpu_wdata,
  input  logic                     cpu_we,
  input  logic [5:0]               bus_hi,
  input  logic [1:0]               cfg_sw,
  output logic [7:0]               cpu_rdata,
  output logic [NUM_WIN*PRG_W-1:0] prg_pages,
  output logic [NUM_WIN*8-1:0]     chr_pages,
  output logic                     mirror_horiz
);

  localparam int unsigned SEL_W = $clog2(SCR_N);

  logic [NUM_REGS-1:0]      reg_wr;
  logic                     scr_wr;
  logic                     sw_area;
  logic                     scr_area;
  logic [7:0]               bank_q;
  logic [7:0]               mode_q;
  logic [NUM_PAGE-1:0][7:0] page_q;
  logic [7:0]               scr_rdata;
  logic [2:0][7:0]          prg_page_lo;

  cbc_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (cpu_addr),
    .we       (cpu_we),
    .reg_wr   (reg_wr),
    .scr_wr   (scr_wr),
    .sw_area  (sw_area),
    .scr_area (scr_area)
  );

  cbc_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .reg_wr   (reg_wr),
    .wdata    (cpu_wdata),
    .bank_q   (bank_q),
    .mode_q   (mode_q),
    .page_q   (page_q)
  );

  cbc_scratch #(.DEPTH(SCR_N)) u_scratch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (scr_wr),
    .sel   (cpu_addr[SEL_W-1:0]),
    .wdata (cpu_wdata),
    .rdata (scr_rdata)
  );

  assign prg_page_lo = {page_q[2], page_q[1], page_q[0]};

  cbc_prg_map #(.PRG_W(PRG_W)) u_prg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .bank      (bank_q),
    .page_lo   (prg_page_lo),
    .prg_pages (prg_pages)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_WIN; c++) begin : g_chr
      assign chr_pages[c*8 +: 8] = page_q[3+c];
    end
  endgenerate

  assign mirror_horiz = mode_q[MODE_MIRROR];

  always_comb begin
    if (sw_area)       cpu_rdata = {bus_hi, cfg_sw};
    else if (scr_area) cpu_rdata = scr_rdata;
    else               cpu_rdata = 8'h00;
  end

  // R3: mirroring follows the stored mode bit
  a_r3_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_horiz == mode_q[MODE_MIRROR]);

  // R11: a captured bank write in split layout shows on window 0 next cycle
  a_r11_bank_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr[REG_BANK] && !soft_rst && mode_q[4:3] == 2'b00 && !reg_wr[REG_MODE]) |=>
      (prg_pages[PRG_W-1:0] == PRG_W'({$past(cpu_wdata), 1'b0})));

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [5:0]  bus_hi = 6'h00;
  logic [1:0]  cfg_sw = 2'b00;
  logic [7:0]  cpu_rdata;
  logic [19:0] prg_pages;
  logic [31:0] chr_pages;
  logic        mirror_horiz;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .bus_hi(bus_hi), .cfg_sw(cfg_sw), .cpu_rdata(cpu_rdata),
    .prg_pages(prg_pages), .chr_pages(chr_pages), .mirror_horiz(mirror_horiz)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  function automatic logic [19:0] pack4(input int a, input int b, input int c, input int d);
    return {5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  task automatic t_reset_state;
    check("R10 prg after power-up", {12'd0, prg_pages}, {12'd0, pack4(0, 1, 30, 31)});
    check("R10 chr after power-up", chr_pages, 32'h0);
    check("R10 mirror after power-up", {31'd0, mirror_horiz}, 32'd0);
  endtask

  task automatic t_split_layout;
    bus_write(16'h8000, 8'h05);
    check("R6 R11 split bank 5", {12'd0, prg_pages}, {12'd0, pack4(10, 11, 30, 31)});
    bus_write(16'h83E8, 8'h13);   // R1 alias of bank register
    check("R1 R6 alias and truncation", {12'd0, prg_pages}, {12'd0, pack4(6, 7, 30, 31)});
  endtask

  task automatic t_whole_layout;
    bus_write(16'h8400, 8'h08);
    bus_write(16'h8000, 8'h07);
    check("R5 whole bank 7", {12'd0, prg_pages}, {12'd0, pack4(12, 13, 14, 15)});
  endtask

  task automatic t_perwin_layout;
    bus_write(16'h8C00, 8'h23);
    bus_write(16'h8C01, 8'h0A);
    bus_write(16'h8C02, 8'h05);
    bus_write(16'h8400, 8'h18);   // R4 per-window wins over whole
    bus_write(16'h8000, 8'h08);
    check("R4 R2 per-window outer set", {12'd0, prg_pages}, {12'd0, pack4(19, 26, 21, 31)});
    bus_write(16'h8000, 8'h00);
    check("R4 per-window outer clear", {12'd0, prg_pages}, {12'd0, pack4(3, 10, 5, 15)});
    bus_write(16'h8C03, 8'hFF);   // R1 undecoded
    bus_write(16'h8800, 8'hFF);
    bus_write(16'h8801, 8'hFF);
    check("R1 undecoded writes ignored", {12'd0, prg_pages}, {12'd0, pack4(3, 10, 5, 15)});
    check("R1 undecoded mirror unchanged", {31'd0, mirror_horiz}, 32'd0);
  endtask

  task automatic t_chr_and_mirror;
    bus_write(16'h8C10, 8'h11);
    bus_write(16'h8C11, 8'h22);
    bus_write(16'h8C16, 8'h33);
    bus_write(16'h8C17, 8'h44);
    check("R2 chr windows", chr_pages, 32'h44332211);
    bus_write(16'h8FF7, 8'h55);   // alias of page byte 6
    check("R2 chr alias", chr_pages, 32'h55332211);
    bus_write(16'h8400, 8'h11);
    check("R3 mirror horizontal", {31'd0, mirror_horiz}, 32'd1);
    check("R4 mode still per-window", {12'd0, prg_pages}, {12'd0, pack4(3, 10, 5, 15)});
  endtask

  task automatic t_scratch_and_switch;
    logic [7:0] d;
    bus_write(16'h5400, 8'hA1);
    bus_write(16'h5401, 8'hB2);
    bus_write(16'h5FFE, 8'hC3);
    bus_write(16'h5403, 8'hD4);
    bus_write(16'h57FF, 8'hE5);
    bus_read(16'h5C03, d); check("R7 scratch 3 overwritten", {24'd0, d}, 32'hE5);
    bus_read(16'h5401, d); check("R7 scratch 1", {24'd0, d}, 32'hB2);
    bus_read(16'h5802, d); check("R7 scratch 2", {24'd0, d}, 32'hC3);
    cfg_sw = 2'b10; bus_hi = 6'b101001;
    bus_read(16'h5000, d); check("R8 switch read", {24'd0, d}, 32'hA6);
    bus_write(16'h5000, 8'hFF);
    bus_write(16'h53FF, 8'hFF);
    bus_read(16'h5400, d); check("R8 switch write ignored s0", {24'd0, d}, 32'hA1);
    bus_read(16'h5C03, d); check("R8 switch write ignored s3", {24'd0, d}, 32'hE5);
    bus_read(16'h6000, d); check("R8 unmapped reads zero", {24'd0, d}, 32'h00);
  endtask

  task automatic t_soft_reset;
    logic [7:0] d;
    bus_write(16'h8000, 8'h08);
    @(negedge clk);
    soft_rst = 1'b1; cpu_addr = 16'h8400; cpu_wdata = 8'h18; cpu_we = 1'b1;
    @(posedge clk); #1;
    soft_rst = 1'b0; cpu_we = 1'b0;
    check("R9 soft reset prg", {12'd0, prg_pages}, {12'd0, pack4(0, 1, 30, 31)});
    check("R9 soft reset mirror", {31'd0, mirror_horiz}, 32'd0);
    check("R9 chr kept", chr_pages, 32'h55332211);
    bus_write(16'h8400, 8'h10);
    check("R9 page bytes kept", {12'd0, prg_pages}, {12'd0, pack4(3, 10, 5, 15)});
    bus_read(16'h5401, d); check("R9 scratch kept", {24'd0, d}, 32'hB2);
  endtask

  task automatic t_power_reset;
    logic [7:0] d;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset_state();
    bus_read(16'h5401, d); check("R10 scratch cleared", {24'd0, d}, 32'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset_state();
    t_split_layout();
    t_whole_layout();
    t_perwin_layout();
    t_chr_and_mirror();
    t_scratch_and_switch();
    t_soft_reset();
    t_power_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule